// File: doc/BRIEF.md
# Lazy Status Flag Evaluator

This unit rebuilds the six arithmetic status flags (overflow, sign, zero, half-carry, carry, parity) from a saved record of the last flag-producing operation, so that a core can skip updating a flags register on every instruction. The record consists of an operation selector, two operand words whose meaning depends on the operation class, and one auxiliary word that carries an old carry bit or an old flags word. The unit also resolves a 5-bit branch condition against the rebuilt flags and returns true or false.

The selector picks both the operation class and the operand width (8, 16, 32 or 64 bits). Selectors or condition codes outside the supported range raise an error output. While it is raised, the flags output is zero and the condition result is false. By default the results pass through one output register. With `OUT_REG = 0` the unit is purely combinational.

Top module: `lazy_flag_unit`

## Requirements
- R1: The flags word places carry at bit 0, parity at bit 2, half-carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Every other bit of the word is 0 (mask 0x8D5).
- R2: Selector 0 is copy: the flags output is the first operand word ANDed with 0x8D5.
- R3: Selectors 1-4 add and 5-8 subtract the two operand words. Within every group of four selectors the widths are 8, 16, 32 and 64 bits, in that order. Carry is the carry out, or the borrow. Overflow is signed overflow. Half-carry is the carry or borrow out of bit 3.
- R4: Selectors 9-12 are add-with-carry and 13-16 are subtract-with-borrow. The old carry is auxiliary bit 0. The real right operand is the second word XOR that bit, and the old carry also enters the sum or difference.
- R5: Selectors 17-20 are logical. The first word is the result, and carry, overflow and half-carry are 0.
- R6: Selectors 21-24 are increment and 25-28 are decrement, with the first word as the result. Carry is auxiliary bit 0. Overflow is set when the result is the most negative value (increment) or the most positive value (decrement). Half-carry is set when the low nibble is 0x0 (increment) or 0xF (decrement).
- R7: Selectors 29-32 are shift left and 33-36 are shift right. The first word is the result and the second is the result shifted one place less. Carry is the top width bit of the second word (left) or its bit 0 (right). Overflow is the XOR of the two words' top width bits, and half-carry is 0.
- R8: Selectors 37-40 are rotate left and 41-44 are rotate right.
  - Rotate left: carry is result bit 0 and overflow is the top bit XOR carry.
  - Rotate right: carry is the top bit and overflow is the top two bits XORed.
  - For both, bits 2, 4, 6 and 7 are copied from the auxiliary word.
- R9: Selectors 45-48 multiply unsigned and 49-52 multiply signed. Carry and overflow are both set when the upper half of the double-width product is not the zero or sign extension of the lower half. Half-carry is 0.
- R10: For the arithmetic classes, zero and sign come from the result truncated to the operation width. Parity is set when the result's low 8 bits hold an even number of ones.
- R11: Condition codes 0-15 form pairs (even code true, odd code its negation). In order the pairs are: overflow, carry, zero, carry-or-zero, sign, parity, sign-xor-overflow, and (sign-xor-overflow)-or-zero. Code 16 is always true.
- R12: A selector above 52 or a condition code above 16 sets the error output. While it is set, the flags output is 0 and the condition result is 0.
- R13: With `OUT_REG = 1`, outputs appear one clock after the inputs are sampled. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 8 | Operation selector of the record |
| dep_a_i | input | 64 | First operand word |
| dep_b_i | input | 64 | Second operand word |
| aux_i | input | 64 | Auxiliary word (old carry or old flags) |
| cond_i | input | 5 | Branch condition code |
| flags_o | output | 64 | Rebuilt flags word |
| cond_true_o | output | 1 | Condition result |
| err_o | output | 1 | Unsupported selector or condition |

## Verification
The assertions assume that all inputs hold known values across each rising edge. They compare each output against the inputs captured one edge earlier. The stimulus changes inputs only on falling edges. The assertions do not require the operand words to be consistent with each other (for example, a shift's second word need not be the real one-step-short value), because the unit must give a defined answer for any record. The stimulus therefore mixes arbitrary words with boundary patterns such as zero, all ones and sign-bit values.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  localparam int OP_W    = 8;
  localparam int CC_W    = 5;
  localparam int WORD_W  = 64;
  localparam int NUM_W   = 4;
  localparam int MIN_W   = 8;
  localparam int LAST_OP = 52;
  localparam int LAST_CC = 16;

  localparam int POS_C = 0;
  localparam int POS_P = 2;
  localparam int POS_A = 4;
  localparam int POS_Z = 6;
  localparam int POS_S = 7;
  localparam int POS_O = 11;

  localparam logic [WORD_W-1:0] KEEP_MASK =
    (WORD_W'(1) << POS_P) | (WORD_W'(1) << POS_A) |
    (WORD_W'(1) << POS_Z) | (WORD_W'(1) << POS_S);
  localparam logic [WORD_W-1:0] FLAG_MASK =
    KEEP_MASK | (WORD_W'(1) << POS_C) | (WORD_W'(1) << POS_O);

  typedef enum logic [3:0] {
    CL_COPY, CL_ADD, CL_SUB, CL_ADC, CL_SBB, CL_LOGIC, CL_INC,
    CL_DEC, CL_SHL, CL_SHR, CL_ROL, CL_ROR, CL_UMUL, CL_SMUL
  } lfu_cls_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic half;
    logic cry;
    logic par;
  } lfu_flags_t;

  function automatic logic [WORD_W-1:0] flags_pack(input lfu_flags_t f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[POS_C] = f.cry;
    w[POS_P] = f.par;
    w[POS_A] = f.half;
    w[POS_Z] = f.zro;
    w[POS_S] = f.sgn;
    w[POS_O] = f.ovf;
    return w;
  endfunction

  function automatic lfu_flags_t flags_unpack(input logic [WORD_W-1:0] w);
    lfu_flags_t f;
    f.cry  = w[POS_C];
    f.par  = w[POS_P];
    f.half = w[POS_A];
    f.zro  = w[POS_Z];
    f.sgn  = w[POS_S];
    f.ovf  = w[POS_O];
    return f;
  endfunction
endpackage

// File: rtl/lfu_opdec.sv
module lfu_opdec
  import lfu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output lfu_cls_e        cls_o,
  output logic [1:0]      wsel_o,
  output logic            bad_o
);
  logic [OP_W-1:0] op_m1;
  logic [3:0]      grp;
  logic            unused_hi;

  assign op_m1     = op_i - OP_W'(1);
  assign grp       = op_m1[5:2];
  assign unused_hi = ^op_m1[OP_W-1:6];

  always_comb begin
    bad_o  = (op_i > OP_W'(LAST_OP));
    wsel_o = op_m1[1:0];
    if (op_i == '0 || bad_o) begin
      cls_o  = CL_COPY;
      wsel_o = 2'd0;
    end else begin
      cls_o = lfu_cls_e'(grp + 4'd1);
    end
  end
endmodule

// File: rtl/lfu_lane.sv
module lfu_lane
  import lfu_pkg::*;
#(
  parameter int W = 8
) (
  input  lfu_cls_e     cls_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  lfu_flags_t   keep_i,
  output lfu_flags_t   fl_o
);
  localparam int W2 = 2 * W;

  logic                 with_c;
  logic [W-1:0]         b_eff;
  logic [W-1:0]         res;
  logic [W:0]           sum;
  logic [W:0]           dif;
  logic [W2-1:0]        uprod;
  logic signed [W2-1:0] sprod;

  always_comb begin
    with_c = (cls_i == CL_ADC) || (cls_i == CL_SBB);
    b_eff  = b_i ^ {{(W-1){1'b0}}, with_c & cin_i};
    sum    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, with_c & cin_i};
    dif    = {1'b0, a_i} - {1'b0, b_eff} - {{W{1'b0}}, with_c & cin_i};
    uprod  = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    sprod  = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
  end

  always_comb begin
    fl_o = '0;
    res  = a_i;
    case (cls_i)
      CL_ADD, CL_ADC: begin
        res       = sum[W-1:0];
        fl_o.cry  = sum[W];
        fl_o.ovf  = ~(a_i[W-1] ^ b_eff[W-1]) & (a_i[W-1] ^ res[W-1]);
        fl_o.half = a_i[4] ^ b_eff[4] ^ res[4];
      end
      CL_SUB, CL_SBB: begin
        res       = dif[W-1:0];
        fl_o.cry  = dif[W];
        fl_o.ovf  = (a_i[W-1] ^ b_eff[W-1]) & (a_i[W-1] ^ res[W-1]);
        fl_o.half = a_i[4] ^ b_eff[4] ^ res[4];
      end
      CL_INC: begin
        fl_o.cry  = cin_i;
        fl_o.ovf  = (res == {1'b1, {(W-1){1'b0}}});
        fl_o.half = (res[3:0] == 4'h0);
      end
      CL_DEC: begin
        fl_o.cry  = cin_i;
        fl_o.ovf  = (res == {1'b0, {(W-1){1'b1}}});
        fl_o.half = (res[3:0] == 4'hF);
      end
      CL_SHL: begin
        fl_o.cry = b_i[W-1];
        fl_o.ovf = a_i[W-1] ^ b_i[W-1];
      end
      CL_SHR: begin
        fl_o.cry = b_i[0];
        fl_o.ovf = a_i[W-1] ^ b_i[W-1];
      end
      CL_ROL: begin
        fl_o.cry = a_i[0];
        fl_o.ovf = a_i[W-1] ^ a_i[0];
      end
      CL_ROR: begin
        fl_o.cry = a_i[W-1];
        fl_o.ovf = a_i[W-1] ^ a_i[W-2];
      end
      CL_UMUL: begin
        res      = uprod[W-1:0];
        fl_o.cry = |uprod[W2-1:W];
        fl_o.ovf = |uprod[W2-1:W];
      end
      CL_SMUL: begin
        res      = sprod[W-1:0];
        fl_o.cry = (sprod[W2-1:W] != {W{sprod[W-1]}});
        fl_o.ovf = (sprod[W2-1:W] != {W{sprod[W-1]}});
      end
      default: ;
    endcase
    if (cls_i == CL_ROL || cls_i == CL_ROR) begin
      fl_o.sgn  = keep_i.sgn;
      fl_o.zro  = keep_i.zro;
      fl_o.half = keep_i.half;
      fl_o.par  = keep_i.par;
    end else begin
      fl_o.sgn = res[W-1];
      fl_o.zro = ~|res;
      fl_o.par = ~^res[7:0];
    end
  end
endmodule

// File: rtl/lfu_cond.sv
module lfu_cond
  import lfu_pkg::*;
(
  input  lfu_flags_t      fl_i,
  input  logic [CC_W-1:0] cc_i,
  output logic            true_o,
  output logic            bad_o
);
  logic base;

  always_comb begin
    case (cc_i[3:1])
      3'd0:    base = fl_i.ovf;
      3'd1:    base = fl_i.cry;
      3'd2:    base = fl_i.zro;
      3'd3:    base = fl_i.cry | fl_i.zro;
      3'd4:    base = fl_i.sgn;
      3'd5:    base = fl_i.par;
      3'd6:    base = fl_i.sgn ^ fl_i.ovf;
      default: base = (fl_i.sgn ^ fl_i.ovf) | fl_i.zro;
    endcase
    bad_o = (cc_i > CC_W'(LAST_CC));
    if (cc_i[4]) true_o = (cc_i == CC_W'(LAST_CC));
    else         true_o = base ^ cc_i[0];
  end
endmodule

// File: rtl/lazy_flag_unit.sv
module lazy_flag_unit
  import lfu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] dep_a_i,
  input  logic [WORD_W-1:0] dep_b_i,
  input  logic [WORD_W-1:0] aux_i,
  input  logic [CC_W-1:0]   cond_i,
  output logic [WORD_W-1:0] flags_o,
  output logic              cond_true_o,
  output logic              err_o
);
  lfu_cls_e    cls;
  logic [1:0]  wsel;
  logic        op_bad;
  lfu_flags_t  keep;
  lfu_flags_t  lane_f [NUM_W];
  lfu_flags_t  calc_f;
  logic        cc_raw;
  logic        cc_bad;

  logic [WORD_W-1:0] flags_d;
  logic              true_d;
  logic              err_d;

  lfu_opdec u_opdec (
    .op_i   (op_i),
    .cls_o  (cls),
    .wsel_o (wsel),
    .bad_o  (op_bad)
  );

  assign keep = flags_unpack(aux_i);

  for (genvar gi = 0; gi < NUM_W; gi++) begin : g_lane
    localparam int LW = MIN_W << gi;
    lfu_lane #(.W(LW)) u_lane (
      .cls_i  (cls),
      .a_i    (dep_a_i[LW-1:0]),
      .b_i    (dep_b_i[LW-1:0]),
      .cin_i  (aux_i[0]),
      .keep_i (keep),
      .fl_o   (lane_f[gi])
    );
  end

  always_comb begin
    if (cls == CL_COPY) calc_f = flags_unpack(dep_a_i);
    else                calc_f = lane_f[wsel];
  end

  lfu_cond u_cond (
    .fl_i   (calc_f),
    .cc_i   (cond_i),
    .true_o (cc_raw),
    .bad_o  (cc_bad)
  );

  always_comb begin
    err_d   = op_bad | cc_bad;
    flags_d = err_d ? '0 : flags_pack(calc_f);
    true_d  = ~err_d & cc_raw;
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_o     <= '0;
        cond_true_o <= 1'b0;
        err_o       <= 1'b0;
      end else begin
        flags_o     <= flags_d;
        cond_true_o <= true_d;
        err_o       <= err_d;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk  = clk_i ^ rst_ni;
    assign flags_o     = flags_d;
    assign cond_true_o = true_d;
    assign err_o       = err_d;
  end
endmodule

// File: rtl/lfu_checker.sv
module lfu_checker
  import lfu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [WORD_W-1:0] dep_a_i,
  input logic [WORD_W-1:0] aux_i,
  input logic [CC_W-1:0]   cond_i,
  input logic [WORD_W-1:0] flags_o,
  input logic              cond_true_o,
  input logic              err_o
);
  logic              live;
  logic [OP_W-1:0]   h_op;
  logic [CC_W-1:0]   h_cc;
  logic [WORD_W-1:0] h_a;
  logic [WORD_W-1:0] h_x;
  logic              h_ok;

  if (OUT_REG) begin : g_seq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live <= 1'b0;
        h_op <= '0;
        h_cc <= '0;
        h_a  <= '0;
        h_x  <= '0;
      end else begin
        live <= 1'b1;
        h_op <= op_i;
        h_cc <= cond_i;
        h_a  <= dep_a_i;
        h_x  <= aux_i;
      end
    end
  end else begin : g_comb
    assign live = 1'b1;
    assign h_op = op_i;
    assign h_cc = cond_i;
    assign h_a  = dep_a_i;
    assign h_x  = aux_i;
  end

  assign h_ok = (h_op <= OP_W'(LAST_OP)) && (h_cc <= CC_W'(LAST_CC));

  a_r1_spare_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~FLAG_MASK) == '0);

  a_r12_error_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (flags_o == '0) && !cond_true_o);

  a_r12_error_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> err_o == !h_ok);

  a_r2_copy_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && h_ok && h_op == '0) |-> flags_o == (h_a & FLAG_MASK));

  a_r8_rotate_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && h_ok && h_op >= OP_W'(37) && h_op <= OP_W'(44))
      |-> (flags_o & KEEP_MASK) == (h_x & KEEP_MASK));

  a_r6_carry_from_aux: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && h_ok && h_op >= OP_W'(21) && h_op <= OP_W'(28))
      |-> flags_o[POS_C] == h_x[0]);

  a_r5_logic_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && h_ok && h_op >= OP_W'(17) && h_op <= OP_W'(20))
      |-> !flags_o[POS_C] && !flags_o[POS_O] && !flags_o[POS_A]);

  a_r11_always_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && h_ok && h_cc == CC_W'(16)) |-> cond_true_o);

  a_r11_zero_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && h_ok && h_cc[4:1] == 4'd2) |-> cond_true_o == (flags_o[POS_Z] ^ h_cc[0]));
endmodule

bind lazy_flag_unit lfu_checker #(.OUT_REG(OUT_REG)) u_lfu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .dep_a_i     (dep_a_i),
  .aux_i       (aux_i),
  .cond_i      (cond_i),
  .flags_o     (flags_o),
  .cond_true_o (cond_true_o),
  .err_o       (err_o)
);

// File: tb/test_lazy_flag_unit.sv
module test_lazy_flag_unit;
  logic        clk;
  logic        rst_n;
  logic [7:0]  op;
  logic [63:0] da, db, dx;
  logic [4:0]  cc;
  logic [63:0] flags;
  logic        ctrue, err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  lazy_flag_unit i_lazy_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .dep_a_i(da), .dep_b_i(db),
    .aux_i(dx), .cond_i(cc), .flags_o(flags), .cond_true_o(ctrue), .err_o(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: flags, condition and error for one record.
  function automatic void model(input int o, input logic [63:0] a, b, x, input int c,
                                output logic [63:0] f, output logic t, output logic e);
    int grp, w;
    logic [63:0] m, sb, av, bv, r, sa, sbv, rr;
    logic [127:0] big;
    logic signed [127:0] sbig;
    bit cin, fc, fo, fh, fz, fs, fp, keep, base;
    e = (o > 52) || (c > 16);
    f = '0; t = 1'b0;
    if (e) return;
    fc = 0; fo = 0; fh = 0; keep = 0; cin = 0;
    if (o == 0) begin
      f = a & 64'h8D5;
    end else begin
      grp = (o - 1) / 4;
      w   = 8 << ((o - 1) % 4);
      m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      sb  = 64'd1 << (w - 1);
      av  = a & m;
      bv  = b & m;
      r   = av;
      if (grp == 2 || grp == 3) begin
        cin = x[0];
        bv  = (b ^ 64'(x[0])) & m;
      end
      case (grp)
        0, 2: begin
          big = {64'd0, av} + {64'd0, bv} + 128'(cin);
          r  = big[63:0] & m;
          fc = (big >> w) != 0;
          fo = ((av & sb) == (bv & sb)) && ((r & sb) != (av & sb));
          fh = ((av & 64'hF) + (bv & 64'hF) + 64'(cin)) > 64'd15;
        end
        1, 3: begin
          big = {64'd0, av} - {64'd0, bv} - 128'(cin);
          r  = big[63:0] & m;
          fc = big[127];
          fo = ((av & sb) != (bv & sb)) && ((r & sb) != (av & sb));
          fh = (av & 64'hF) < ((bv & 64'hF) + 64'(cin));
        end
        5: begin fc = x[0]; fo = (r == sb); fh = (r & 64'hF) == 0; end
        6: begin fc = x[0]; fo = (r == sb - 64'd1); fh = (r & 64'hF) == 64'hF; end
        7: begin fc = (bv & sb) != 0; fo = ((av ^ bv) & sb) != 0; end
        8: begin fc = bv[0]; fo = ((av ^ bv) & sb) != 0; end
        9: begin fc = r[0]; fo = ((r & sb) != 0) ^ r[0]; keep = 1; end
        10: begin fc = (r & sb) != 0; fo = fc ^ ((r & (sb >> 1)) != 0); keep = 1; end
        11: begin
          big = {64'd0, av} * {64'd0, bv};
          r  = big[63:0] & m;
          fc = (big >> w) != 0;
          fo = fc;
        end
        12: begin
          sa   = ((av & sb) != 0) ? (av | ~m) : av;
          sbv  = ((bv & sb) != 0) ? (bv | ~m) : bv;
          sbig = $signed({{64{sa[63]}}, sa}) * $signed({{64{sbv[63]}}, sbv});
          r    = sbig[63:0] & m;
          rr   = ((r & sb) != 0) ? (r | ~m) : r;
          fc   = sbig != $signed({{64{rr[63]}}, rr});
          fo   = fc;
        end
        default: ;
      endcase
      fz = (r == 0);
      fs = (r & sb) != 0;
      fp = ($countones(r[7:0]) % 2) == 0;
      if (keep) begin fh = x[4]; fz = x[6]; fs = x[7]; fp = x[2]; end
      f[0] = fc; f[2] = fp; f[4] = fh; f[6] = fz; f[7] = fs; f[11] = fo;
    end
    case (c / 2)
      0: base = f[11];
      1: base = f[0];
      2: base = f[6];
      3: base = f[0] | f[6];
      4: base = f[7];
      5: base = f[2];
      6: base = f[7] != f[11];
      default: base = (f[7] != f[11]) | f[6];
    endcase
    t = (c == 16) ? 1'b1 : (base ^ c[0]);
  endfunction

  function automatic string req_of(input int o, input int c);
    if (o > 52 || c > 16) return "R12";
    if (o == 0) return "R2";
    case ((o - 1) / 4)
      0, 1:   return "R3";
      2, 3:   return "R4";
      4:      return "R5";
      5, 6:   return "R6";
      7, 8:   return "R7";
      9, 10:  return "R8";
      default: return "R9";
    endcase
  endfunction

  // Directed record with hand-computed expectations.
  task automatic dir(input int o, input logic [63:0] a, b, x, input int c,
                     input string req, input logic [63:0] ef, input logic et, input logic ee);
    @(negedge clk);
    op = 8'(o); da = a; db = b; dx = x; cc = 5'(c);
    @(negedge clk);
    chk(req, "flags", flags, ef);
    chk((ee ? "R12" : "R11"), "cond", 64'(ctrue), 64'(et));
    chk("R12", "err", 64'(err), 64'(ee));
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return 64'd0;
      1: return '1;
      2: return 64'h80 << (8 * ($urandom % 8));
      3: return {$urandom, $urandom};
      4: return 64'($urandom % 256);
      default: return 64'h7F << (8 * ($urandom % 8));
    endcase
  endfunction

  logic [63:0] p_f;
  logic        p_t, p_e;
  string       p_req;
  bit          pend;

  initial begin
    rst_n = 1'b0; op = '0; da = '0; db = '0; dx = '0; cc = '0; pend = 0;
    repeat (3) @(negedge clk);
    chk("R13", "reset flags", flags, 64'd0);
    chk("R13", "reset cond", 64'(ctrue), 64'd0);
    chk("R13", "reset err", 64'(err), 64'd0);
    rst_n = 1'b1;

    dir(0,  '1, 0, 0, 16, "R1", 64'h8D5, 1, 0);            // R1 R2
    dir(1,  64'hFF, 64'h01, 0, 2, "R3", 64'h55, 1, 0);
    dir(5,  64'h00, 64'h01, 0, 12, "R3", 64'h95, 1, 0);
    dir(1,  64'h7F, 64'h01, 0, 0, "R3", 64'h890, 1, 0);
    dir(9,  64'hFF, 64'h01, 64'h1, 5, "R4", 64'h55, 0, 0);
    dir(13, 64'h00, 64'h01, 64'h1, 6, "R4", 64'h95, 1, 0);
    dir(17, 64'h103, 0, 0, 10, "R5", 64'h04, 1, 0);        // R10 truncation too
    dir(21, 64'h80, 0, 64'h1, 15, "R6", 64'h891, 1, 0);
    dir(25, 64'h7F, 0, 64'h0, 13, "R6", 64'h810, 0, 0);
    dir(29, 64'h80, 64'h40, 0, 9, "R7", 64'h880, 0, 0);
    dir(33, 64'h00, 64'h01, 0, 4, "R7", 64'h45, 1, 0);
    dir(37, 64'h01, 0, 64'hD4, 7, "R8", 64'h8D5, 0, 0);
    dir(45, 64'h10, 64'h10, 0, 1, "R9", 64'h845, 0, 0);
    dir(49, 64'hFF, 64'hFF, 0, 3, "R9", 64'h000, 1, 0);
    dir(45, 64'hFF, 64'hFF, 0, 3, "R9", 64'h801, 0, 0);
    dir(2,  64'h8000, 64'h8000, 0, 14, "R10", 64'h845, 1, 0);
    dir(18, 64'h0100, 0, 0, 11, "R10", 64'h04, 0, 0);
    dir(53, '1, '1, '1, 16, "R12", 64'h0, 0, 1);
    dir(0,  '1, 0, 0, 17, "R12", 64'h0, 0, 1);

    // Random records, compared against the model every clock (R13 latency).
    for (int k = 0; k < 4000; k++) begin
      int o, c;
      @(negedge clk);
      if (pend) begin
        chk(p_req, "flags", flags, p_f);
        chk((p_e ? "R12" : "R11"), "cond", 64'(ctrue), 64'(p_t));
        chk("R12", "err", 64'(err), 64'(p_e));
      end
      o = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 64);
      c = int'($urandom % 21);
      op = 8'(o); da = pick(); db = pick(); dx = pick(); cc = 5'(c);
      model(o, da, db, dx, c, p_f, p_t, p_e);
      p_req = req_of(o, c);
      pend = 1;
    end
    @(negedge clk);
    chk(p_req, "flags", flags, p_f);
    chk((p_e ? "R12" : "R11"), "cond", 64'(ctrue), 64'(p_t));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule